// File: doc/BRIEF.md
# Chunked Atomic Register Multiplexer

This block places a fixed set of peripheral registers, each of any width, behind a narrow register bus. The bus carries an address, a read strobe with registered read data, and a write strobe with write data. Each register is cut into bus-width chunks. The chunks sit at consecutive addresses, with the least significant chunk at the lowest address. This lets software reach registers much wider than the bus.

Atomicity comes from two shadow buffers per register. A read of the lowest chunk snapshots the whole register, and later chunk reads are served from that snapshot. Writes to the lower chunks are collected in a write shadow. The full value goes to the peripheral only when the final address of the register's footprint is written. An alignment parameter rounds every footprint up to a multiple of A addresses. This moves the commit point to the last address of the rounded footprint, so the write cost follows from the address span alone.

On the peripheral side, every register gets its own live value input, a read pulse for read side effects, a committed value output and a write pulse. Register widths, base addresses, bus widths and alignment are all set at elaboration time.

Top module: `csr_chunk_mux`

## Requirements
- R1: Register i occupies footprint addresses starting at its base. The chunk holding value bits [k*DATA_W +: DATA_W] is at base+k. A top chunk that is only partly used reads with its unused upper bits as zero.
- R2: A bus read strobe at a register's base address pulses that register's `per_rd_stb` bit in the same cycle. On that edge the whole live value is captured into the read shadow.
- R3: A bus read strobe at chunk k>0 returns slice k of the read shadow. Changes to the live value after the capture do not affect it.
- R4: `bus_rd_data` is updated on the cycle after a read strobe. On every cycle that does not follow a read strobe it is zero. It is also zero after a read of an address that no register maps.
- R5: A bus write at a data chunk other than the commit address stores the data into that slice of the write shadow. It raises no `per_wr_stb`. Stored slices persist across commits until they are rewritten.
- R6: A bus write at a register's commit address pulses `per_wr_stb` for exactly one cycle, one cycle after the bus strobe. `per_wr_data` then holds the full shadow, with the current chunk's data if that address is a data chunk.
- R7: With alignment A, each footprint is ceil(chunks/A)*A addresses. The commit address is the last of these. A 24-bit register on an 8-bit bus with A=4 commits on its 4th address.
- R8: Padding addresses inside a footprint read as zero. Writes to them change no register bits, and at the commit address their data is discarded.
- R9: No two footprints overlap, so at most one register decodes any address. Writes to unmapped addresses produce no peripheral write pulse.
- R10: Reset clears both shadows of every register, the peripheral write outputs and the read data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Chunk address |
| bus_rd_stb | input | 1 | Bus read strobe |
| bus_rd_data | output | DATA_W | Registered read data, zero when idle |
| bus_wr_stb | input | 1 | Bus write strobe |
| bus_wr_data | input | DATA_W | Bus write data |
| per_rd_data | input | sum of REG_W | Live register values, register 0 in the low bits |
| per_rd_stb | output | NREG | Per-register read side-effect pulse |
| per_wr_data | output | sum of REG_W | Committed register values, register 0 in the low bits |
| per_wr_stb | output | NREG | Per-register commit pulse |

## Verification
The bench uses the default build: an 8-bit bus, 5 address bits, alignment 4, and three registers of 24, 8 and 12 bits at bases 0, 4 and 12. This layout leaves a gap at addresses 8 to 11. Each register therefore has at least one padding address. One register has a partly filled top chunk. The commit address is always a padding slot, which exercises the alignment-driven commit and the discarding of padding data. The gap and the top address provide unmapped reads and writes.

// File: rtl/csr_chunk_pkg.sv
package csr_chunk_pkg;

  // number of bus chunks a register of width w needs on a bus of width dw
  function automatic int chunk_count(input int w, input int dw);
    return (w + dw - 1) / dw;
  endfunction

  // addresses a register occupies once rounded up to the alignment
  function automatic int footprint(input int w, input int dw, input int align);
    int n;
    int a;
    n = chunk_count(w, dw);
    a = (align < 1) ? 1 : align;
    return ((n + a - 1) / a) * a;
  endfunction

endpackage

// File: rtl/csr_slot.sv
module csr_slot
  import csr_chunk_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int REG_W  = 24,
  parameter int BASE   = 0,
  parameter int ALIGN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_stb,
  input  logic              bus_wr_stb,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic [REG_W-1:0]  per_rd_data,
  output logic              per_rd_stb,
  output logic [REG_W-1:0]  per_wr_data,
  output logic              per_wr_stb,
  output logic [DATA_W-1:0] rd_cand,
  output logic              hit
);

  localparam int NCH  = chunk_count(REG_W, DATA_W);
  localparam int FOOT = footprint(REG_W, DATA_W, ALIGN);
  localparam int SW   = NCH * DATA_W;
  localparam int LIM  = BASE + FOOT;

  if (LIM > (1 << ADDR_W)) begin : g_fit_err
    $error("register footprint exceeds the address space");
  end

  // ---------------- decode ----------------
  int              offs;
  logic            is_first;
  logic            is_last;
  logic            in_data;
  logic [NCH-1:0]  chunk_sel;

  always_comb begin
    offs     = int'({1'b0, bus_addr}) - BASE;
    hit      = (offs >= 0) && (offs < FOOT);
    is_first = hit && (offs == 0);
    is_last  = hit && (offs == FOOT - 1);
    in_data  = hit && (offs < NCH);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign chunk_sel[c] = hit && (offs == c);
  end

  // named events
  logic capture;
  logic commit;
  logic pad_write;
  assign capture   = bus_rd_stb && is_first;
  assign commit    = bus_wr_stb && is_last;
  assign pad_write = bus_wr_stb && hit && !in_data && !is_last;

  // ---------------- read side ----------------
  logic [SW-1:0] live_pad;
  logic [SW-1:0] rd_shadow;
  logic [SW-1:0] rd_src;

  always_comb begin
    live_pad = '0;
    live_pad[REG_W-1:0] = per_rd_data;
  end

  assign per_rd_stb = capture;
  assign rd_src     = is_first ? live_pad : rd_shadow;

  always_comb begin
    rd_cand = '0;
    if (bus_rd_stb) begin
      for (int c = 0; c < NCH; c++) begin
        if (chunk_sel[c]) rd_cand = rd_src[c*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_shadow <= '0;
    else if (capture) rd_shadow <= live_pad;
  end

  // ---------------- write side ----------------
  logic [SW-1:0] wr_shadow;
  logic [SW-1:0] wr_merged;

  always_comb begin
    wr_merged = wr_shadow;
    for (int c = 0; c < NCH; c++) begin
      if (chunk_sel[c]) wr_merged[c*DATA_W +: DATA_W] = bus_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_shadow   <= '0;
      per_wr_data <= '0;
      per_wr_stb  <= 1'b0;
    end else begin
      per_wr_stb <= commit;
      if (bus_wr_stb && in_data && !is_last) wr_shadow <= wr_merged;
      if (commit) per_wr_data <= wr_merged[REG_W-1:0];
    end
  end

  // ---------------- assertions ----------------
  p_commit_next_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> per_wr_stb);

  p_commit_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_stb |-> $past(commit));

  p_capture_whole_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (rd_shadow == $past(live_pad)));

  p_pad_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pad_write |=> $stable(wr_shadow));

  p_pad_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_stb && hit && !in_data) |-> (rd_cand == '0));

endmodule

// File: rtl/csr_rd_merge.sv
module csr_rd_merge #(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [N*DW-1:0] cand,
  output logic [DW-1:0]   rd_data
);

  logic [DW-1:0] merged;

  // candidates are zero unless their slot decodes a read, so OR is a mux
  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++) merged = merged | cand[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= merged;
  end

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (rd_data == '0));

endmodule

// File: rtl/csr_chunk_mux.sv
module csr_chunk_mux
  import csr_chunk_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int ALIGN  = 4,
  parameter int NREG   = 3,
  parameter int REG_W    [NREG] = '{24, 8, 12},
  parameter int REG_BASE [NREG] = '{0, 4, 12},
  localparam int TOT_W = width_before(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_stb,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic              bus_wr_stb,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic [TOT_W-1:0]  per_rd_data,
  output logic [NREG-1:0]   per_rd_stb,
  output logic [TOT_W-1:0]  per_wr_data,
  output logic [NREG-1:0]   per_wr_stb
);

  function automatic int width_before(input int idx);
    int s;
    s = 0;
    for (int k = 0; k < idx; k++) s += REG_W[k];
    return s;
  endfunction

  logic [NREG*DATA_W-1:0] cand;
  logic [NREG-1:0]        slot_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam int OFF = width_before(i);
    localparam int W   = REG_W[i];

    csr_slot #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .REG_W  (W),
      .BASE   (REG_BASE[i]),
      .ALIGN  (ALIGN)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_rd_stb  (bus_rd_stb),
      .bus_wr_stb  (bus_wr_stb),
      .bus_wr_data (bus_wr_data),
      .per_rd_data (per_rd_data[OFF +: W]),
      .per_rd_stb  (per_rd_stb[i]),
      .per_wr_data (per_wr_data[OFF +: W]),
      .per_wr_stb  (per_wr_stb[i]),
      .rd_cand     (cand[i*DATA_W +: DATA_W]),
      .hit         (slot_hit[i])
    );
  end

  csr_rd_merge #(
    .N  (NREG),
    .DW (DATA_W)
  ) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (bus_rd_stb),
    .cand    (cand),
    .rd_data (bus_rd_data)
  );

  p_single_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));

  p_one_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_wr_stb));

endmodule

// File: tb/csr_chunk_mux_bench.sv
`timescale 1ns/1ps
module csr_chunk_mux_bench;

  localparam int ADDR_W = 5;
  localparam int DW     = 8;
  localparam int NREG   = 3;
  localparam int TOT_W  = 44;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rd_stb;
  logic [DW-1:0]     bus_rd_data;
  logic              bus_wr_stb;
  logic [DW-1:0]     bus_wr_data;
  logic [TOT_W-1:0]  per_rd_data;
  logic [NREG-1:0]   per_rd_stb;
  logic [TOT_W-1:0]  per_wr_data;
  logic [NREG-1:0]   per_wr_stb;

  logic [23:0] p0;
  logic [7:0]  p1;
  logic [11:0] p2;
  assign per_rd_data = {p2, p1, p0};

  always #2 clk = ~clk;

  csr_chunk_mux u_csr_chunk_mux (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_stb(bus_rd_stb),
    .bus_rd_data(bus_rd_data), .bus_wr_stb(bus_wr_stb), .bus_wr_data(bus_wr_data),
    .per_rd_data(per_rd_data), .per_rd_stb(per_rd_stb),
    .per_wr_data(per_wr_data), .per_wr_stb(per_wr_stb)
  );

  int total = 0;
  int bad   = 0;

  string       rq_tag[$];
  logic [7:0]  rq_exp[$];
  string       wq_tag[$];
  int          wq_idx[$];
  logic [23:0] wq_val[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic        rd_seen = 1'b0;
  logic [7:0]  m_exp;
  string       m_tag;
  logic [23:0] m_val;
  logic [23:0] m_got;
  int          m_idx;

  always @(posedge clk) rd_seen <= rst_n && bus_rd_stb;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_seen) begin
        if (rq_exp.size() == 0) check(0, "R4", "read with no expectation", bus_rd_data, 0);
        else begin
          m_exp = rq_exp.pop_front();
          m_tag = rq_tag.pop_front();
          check(bus_rd_data == m_exp, m_tag, "bus read data", bus_rd_data, m_exp);
        end
      end else begin
        check(bus_rd_data == '0, "R4", "idle read data", bus_rd_data, 0);
      end
      for (int i = 0; i < NREG; i++) begin
        if (per_wr_stb[i]) begin
          case (i)
            0:       m_got = per_wr_data[23:0];
            1:       m_got = {16'h0, per_wr_data[31:24]};
            default: m_got = {12'h0, per_wr_data[43:32]};
          endcase
          if (wq_idx.size() == 0) check(0, "R5", "unexpected commit pulse", i, -1);
          else begin
            m_idx = wq_idx.pop_front();
            m_val = wq_val.pop_front();
            m_tag = wq_tag.pop_front();
            check(m_idx == i, m_tag, "commit register index", i, m_idx);
            check(m_got == m_val, m_tag, "commit value", m_got, m_val);
          end
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic rd(input int a, input logic [7:0] exp, input logic [2:0] stb_exp,
                    input string tag);
    @(negedge clk);
    bus_addr   = a[ADDR_W-1:0];
    bus_rd_stb = 1'b1;
    bus_wr_stb = 1'b0;
    #1;
    check(per_rd_stb == stb_exp, tag, "peripheral read pulse", per_rd_stb, stb_exp);
    rq_exp.push_back(exp);
    rq_tag.push_back(tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr    = a[ADDR_W-1:0];
    bus_wr_data = d;
    bus_wr_stb  = 1'b1;
    bus_rd_stb  = 1'b0;
  endtask

  task automatic expect_commit(input int idx, input logic [23:0] v, input string tag);
    wq_idx.push_back(idx);
    wq_val.push_back(v);
    wq_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd_stb = 1'b0;
    bus_wr_stb = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd_stb = 1'b0; bus_wr_stb = 1'b0;
    bus_wr_data = '0; p0 = '0; p1 = '0; p2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_rd_data == '0, "R10", "read data in reset", bus_rd_data, 0);
    check(per_wr_stb == '0, "R10", "commit pulse in reset", per_wr_stb, 0);
    check(per_wr_data == '0, "R10", "committed value in reset", per_wr_data[23:0], 0);
    rst_n = 1'b1;

    // shadows start cleared
    p0 = 24'hDEAD77;
    rd(1, 8'h00, 3'b000, "R10");
    expect_commit(2, 24'h000, "R10");
    wr(15, 8'h5C);
    idle();

    // atomic read of the 24-bit register
    p0 = 24'hA1B2C3;
    rd(0, 8'hC3, 3'b001, "R2");
    rd(1, 8'hB2, 3'b000, "R3");
    p0 = 24'h111111;
    rd(2, 8'hA1, 3'b000, "R3");
    rd(3, 8'h00, 3'b000, "R8");
    rd(9, 8'h00, 3'b000, "R4");
    rd(31, 8'h00, 3'b000, "R4");
    idle();

    // chunked write, commit at the padded fourth address
    wr(0, 8'h11);
    wr(1, 8'h22);
    wr(2, 8'h33);
    idle();
    #1;
    check(per_wr_stb == '0, "R5", "no pulse on data chunk write", per_wr_stb, 0);
    expect_commit(0, 24'h332211, "R7");
    wr(3, 8'h99);
    idle();
    idle();

    // single-chunk register with three padding addresses
    p1 = 8'h5A;
    rd(4, 8'h5A, 3'b010, "R1");
    rd(5, 8'h00, 3'b000, "R8");
    rd(7, 8'h00, 3'b000, "R8");
    wr(4, 8'h77);
    wr(5, 8'hEE);
    wr(6, 8'hEE);
    expect_commit(1, 24'h000077, "R8");
    wr(7, 8'h00);
    idle();

    // 12-bit register, partly filled top chunk
    p2 = 12'hABC;
    rd(12, 8'hBC, 3'b100, "R1");
    rd(13, 8'h0A, 3'b000, "R1");
    rd(14, 8'h00, 3'b000, "R8");
    wr(12, 8'h34);
    wr(13, 8'hF5);
    expect_commit(2, 24'h000534, "R6");
    wr(15, 8'h00);
    idle();

    // unmapped writes
    wr(9, 8'hFF);
    wr(10, 8'hFF);
    idle();
    idle();
    #1;
    check(per_wr_stb == '0, "R9", "no pulse on unmapped write", per_wr_stb, 0);

    // older slices persist across commits
    expect_commit(0, 24'h3322AA, "R5");
    wr(0, 8'hAA);
    wr(3, 8'h00);
    idle();
    idle();
    idle();

    check(rq_exp.size() == 0 && wq_idx.size() == 0, "R6", "outstanding expectations",
          rq_exp.size() + wq_idx.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule